// File: doc/BRIEF.md
# Memory Bitfield Access Unit

This unit performs one bitfield operation on a bit string held in byte-addressed, big-endian memory. A request gives a base byte address, a signed bit offset and a width code. The unit finds the smallest memory window that holds the whole field and fetches it with one access of byte, word, long or quad size. It then either extracts a value or modifies the field and writes the window back.

Seven operations are supported. Unsigned extract and signed extract return the field. Insert, change, clear and set update the field in memory. Find-first-one returns the bit position of the first set bit. Condition-code flags are not produced here. The integer unit derives them from the returned value or from the old field.

Top module: `bitfield_mem_unit`

## Requirements
- R1: `widthCode` gives the field width in bits from 1 to 31. The code 0 selects a width of 32.
- R2: The start byte is `baseAddr` plus the bit offset divided by 8 and rounded toward minus infinity. The bit position inside that byte is the offset modulo 8, always taken as 0..7, so negative offsets reach bytes below the base.
- R3: The span is (bit position in byte + width - 1) / 8. Spans 0, 1, 2..3 and 4 use `memSize` codes 0 (1 byte), 1 (2 bytes), 2 (4 bytes) and 3 (8 bytes). `memRdata`/`memWdata` carry the accessed bytes in their low bits, and the byte at the lowest address is the most significant.
- R4: A span-2 field whose start byte is odd is fetched as a long from the byte before it. A span-4 field is fetched as a quad from the start byte rounded down to a multiple of 4. In both cases the field itself is unchanged.
- R5: Field bit 0 is the most significant field bit and lies at the bit offset, where bit 0 of a byte is its MSB. `op` 0 returns the field zero-extended to 32 bits and `op` 1 returns it sign-extended. `op` 7 behaves like `op` 0.
- R6: `op` 2 (insert) replaces the field with the low width bits of `srcValue` and returns `srcValue` shifted left by (32 - width).
- R7: `op` 3, 4 and 5 invert, clear and set every field bit respectively. Each returns the old field left-aligned in 32 bits with zeros below it. Memory bits outside the field are never changed.
- R8: `op` 6 returns the bit offset plus the number of leading zeros of the field. When the field is all zeros it returns the bit offset plus the width.
- R9: A modifying operation makes exactly one read followed by exactly one write, to the same address and size. Extract and find operations make exactly one read.
- R10: `memReq` stays high with stable `memAddr`/`memSize` until `memAck`. `done` is a one-cycle pulse. A `start` pulse while `busy` is high is ignored.
- R11: After reset `busy`, `done` and `memReq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept a request when not busy |
| op | input | 3 | Operation code |
| baseAddr | input | ADDR_W | Base byte address |
| bitOffset | input | 32 | Signed bit offset |
| widthCode | input | 5 | Field width, 0 means 32 |
| srcValue | input | 32 | Insert source |
| busy | output | 1 | Request in progress |
| done | output | 1 | Result valid, one cycle |
| result | output | 32 | Operation result, held until next start |
| memReq | output | 1 | Memory request |
| memWrite | output | 1 | Request is a write |
| memAddr | output | ADDR_W | Access byte address |
| memSize | output | 2 | Access size code |
| memWdata | output | 64 | Write data, right-aligned |
| memAck | input | 1 | Access complete |
| memRdata | input | 64 | Read data, right-aligned |

## Verification
The bench keeps its own bit-addressed model of memory and computes every field bit by bit, so it does not share the window arithmetic with the design. The directed cases target the following faults:
- A 32-bit width code of 0 that is mishandled would collapse the field to nothing.
- A negative offset split with truncating division would point one byte too high.
- A missing realignment of a span-2 field at an odd address, or of a span-4 field, would show up as a wrong access address.
- A find over an all-zero field that returns the leading-zero count would miss the width term.
- Signed extract is tested with the top field bit set, and insert is tested with source bits above the width.

A request repeated while busy must leave both the result and memory unchanged.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  localparam int FIELD_W = 32;
  localparam int WIN_W   = 64;

  typedef enum logic [2:0] {
    OP_EXTU = 3'd0, OP_EXTS = 3'd1, OP_INS = 3'd2, OP_CHG = 3'd3,
    OP_CLR  = 3'd4, OP_SET  = 3'd5, OP_FFO = 3'd6, OP_RSV = 3'd7
  } bfOp_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_LONG = 2'd2, SZ_QUAD = 2'd3
  } memSize_e;

  typedef struct packed {
    logic loadReq;
    logic loadWin;
  } ctrlStrobe_t;
endpackage

// File: rtl/bfu_plan.sv
module bfu_plan
  import bfu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic signed [31:0] bitOffset,
  input  logic [4:0]        widthCode,
  output logic [ADDR_W-1:0] winAddr,
  output logic [5:0]        winBofs,
  output logic [5:0]        fieldLen,
  output memSize_e          winSize
);
  logic [ADDR_W-1:0] byteAddr;
  logic [6:0]        spanSum;
  logic [2:0]        span;
  logic signed [31:0] byteStep;

  assign fieldLen = (widthCode == 5'd0) ? 6'd32 : {1'b0, widthCode};
  // floor division by 8: arithmetic shift rounds toward minus infinity
  assign byteStep = bitOffset >>> 3;
  assign byteAddr = baseAddr + ADDR_W'(byteStep);
  assign spanSum  = 7'(bitOffset[2:0]) + 7'(fieldLen) - 7'd1;
  assign span     = spanSum[5:3];

  always_comb begin
    winAddr = byteAddr;
    winBofs = 6'(bitOffset[2:0]);
    winSize = SZ_QUAD;
    case (span)
      3'd0: winSize = SZ_BYTE;
      3'd1: winSize = SZ_WORD;
      3'd2: begin
        winSize = SZ_LONG;
        if (byteAddr[0]) begin
          winAddr = byteAddr - ADDR_W'(1);
          winBofs = 6'(bitOffset[2:0]) + 6'd8;
        end
      end
      3'd3: winSize = SZ_LONG;
      default: begin
        winAddr = {byteAddr[ADDR_W-1:2], 2'b00};
        winBofs = 6'(bitOffset[2:0]) + {1'b0, byteAddr[1:0], 3'b000};
      end
    endcase
  end
endmodule

// File: rtl/bfu_datapath.sv
module bfu_datapath
  import bfu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [2:0]        opIn,
  input  logic [ADDR_W-1:0] planAddr,
  input  logic [5:0]        planBofs,
  input  logic [5:0]        planLen,
  input  memSize_e          planSize,
  input  logic [31:0]       bitOffset,
  input  logic [31:0]       srcValue,
  input  logic [WIN_W-1:0]  memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        memSize,
  output logic [WIN_W-1:0]  memWdata,
  output logic              needWrite,
  output logic [FIELD_W-1:0] result
);
  bfOp_e             opReg;
  logic [ADDR_W-1:0] addrReg;
  logic [5:0]        bofsReg, lenReg;
  memSize_e          sizeReg;
  logic [31:0]       ofsReg, srcReg;
  logic [WIN_W-1:0]  winReg;

  logic [6:0]        padBits;
  logic [WIN_W-1:0]  fieldMask, fieldTop, insBits, newWin;
  logic [FIELD_W-1:0] oldField, extU;
  logic signed [FIELD_W-1:0] sField, extS;
  logic [5:0]        rShift, zeroCount;

  function automatic logic [5:0] leadZeros(input logic [31:0] v);
    logic [5:0] cnt;
    cnt = 6'd32;
    for (int i = 0; i < 32; i++) if (v[i]) cnt = 6'(31 - i);
    return cnt;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg <= OP_EXTU; addrReg <= '0; bofsReg <= '0; lenReg <= 6'd32;
      sizeReg <= SZ_BYTE; ofsReg <= '0; srcReg <= '0; winReg <= '0;
    end else begin
      if (strobe.loadReq) begin
        opReg <= bfOp_e'(opIn); addrReg <= planAddr; bofsReg <= planBofs;
        lenReg <= planLen; sizeReg <= planSize; ofsReg <= bitOffset;
        srcReg <= srcValue;
      end
      if (strobe.loadWin) winReg <= memRdata << padBits;
    end
  end

  always_comb begin
    case (sizeReg)
      SZ_BYTE: padBits = 7'd56;
      SZ_WORD: padBits = 7'd48;
      SZ_LONG: padBits = 7'd32;
      default: padBits = 7'd0;
    endcase
  end

  assign fieldMask = (~64'd0 << (7'd64 - {1'b0, lenReg})) >> bofsReg;
  assign fieldTop  = (winReg & fieldMask) << bofsReg;
  assign oldField  = fieldTop[63:32];
  assign rShift    = 6'd32 - lenReg;
  assign extU      = oldField >> rShift;
  assign sField    = oldField;
  assign extS      = sField >>> rShift;
  assign insBits   = ({32'd0, srcReg} << (7'd64 - {1'b0, lenReg})) >> bofsReg;
  assign zeroCount = (oldField == '0) ? lenReg : leadZeros(oldField);

  always_comb begin
    case (opReg)
      OP_INS:  newWin = (winReg & ~fieldMask) | insBits;
      OP_CHG:  newWin = winReg ^ fieldMask;
      OP_CLR:  newWin = winReg & ~fieldMask;
      OP_SET:  newWin = winReg | fieldMask;
      default: newWin = winReg;
    endcase
    case (opReg)
      OP_EXTS: result = extS;
      OP_INS:  result = srcReg << rShift;
      OP_CHG, OP_CLR, OP_SET: result = oldField;
      OP_FFO:  result = ofsReg + 32'(zeroCount);
      default: result = extU;
    endcase
  end

  assign needWrite = (opReg == OP_INS) || (opReg == OP_CHG) ||
                     (opReg == OP_CLR) || (opReg == OP_SET);
  assign memWdata  = newWin >> padBits;
  assign memAddr   = addrReg;
  assign memSize   = sizeReg;
endmodule

// File: rtl/bfu_ctrl.sv
module bfu_ctrl
  import bfu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        memAck,
  input  logic        needWrite,
  output ctrlStrobe_t strobe,
  output logic        memReq,
  output logic        memWrite,
  output logic        busy,
  output logic        done
);
  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE, S_DONE} state_e;
  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe    = '0;
    memReq    = 1'b0;
    memWrite  = 1'b0;
    nextState = state;
    case (state)
      S_IDLE: if (start) begin
        strobe.loadReq = 1'b1;
        nextState      = S_READ;
      end
      S_READ: begin
        memReq = 1'b1;
        if (memAck) begin
          strobe.loadWin = 1'b1;
          nextState      = needWrite ? S_WRITE : S_DONE;
        end
      end
      S_WRITE: begin
        memReq   = 1'b1;
        memWrite = 1'b1;
        if (memAck) nextState = S_DONE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);
endmodule

// File: rtl/bitfield_mem_unit.sv
module bitfield_mem_unit
  import bfu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [31:0]       bitOffset,
  input  logic [4:0]        widthCode,
  input  logic [31:0]       srcValue,
  output logic              busy,
  output logic              done,
  output logic [31:0]       result,
  output logic              memReq,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        memSize,
  output logic [63:0]       memWdata,
  input  logic              memAck,
  input  logic [63:0]       memRdata
);
  ctrlStrobe_t       strobe;
  logic [ADDR_W-1:0] planAddr;
  logic [5:0]        planBofs, planLen;
  memSize_e          planSize;
  logic              needWrite;

  bfu_plan #(.ADDR_W(ADDR_W)) u_plan (
    .baseAddr(baseAddr), .bitOffset(bitOffset), .widthCode(widthCode),
    .winAddr(planAddr), .winBofs(planBofs), .fieldLen(planLen),
    .winSize(planSize)
  );

  bfu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .memAck(memAck),
    .needWrite(needWrite), .strobe(strobe), .memReq(memReq),
    .memWrite(memWrite), .busy(busy), .done(done)
  );

  bfu_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opIn(op),
    .planAddr(planAddr), .planBofs(planBofs), .planLen(planLen),
    .planSize(planSize), .bitOffset(bitOffset), .srcValue(srcValue),
    .memRdata(memRdata), .memAddr(memAddr), .memSize(memSize),
    .memWdata(memWdata), .needWrite(needWrite), .result(result)
  );
endmodule

// File: rtl/bfu_checker.sv
module bfu_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              memReq,
  input logic              memWrite,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic [1:0]        memSize
);
  logic [ADDR_W-1:0] rdAddr;
  logic [1:0]        rdSize;
  logic              readSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdAddr <= '0; rdSize <= '0; readSeen <= 1'b0;
    end else begin
      if (memReq && !memWrite && memAck) begin
        rdAddr <= memAddr; rdSize <= memSize; readSeen <= 1'b1;
      end else if (done) begin
        readSeen <= 1'b0;
      end
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memSize));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq);
  // R9
  rmw_same_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWrite |-> readSeen && memAddr == rdAddr && memSize == rdSize);
  // R4
  quad_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memSize == 2'd3 |-> memAddr[1:0] == 2'b00);
endmodule

bind bitfield_mem_unit bfu_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .memReq(memReq),
  .memWrite(memWrite), .memAck(memAck), .memAddr(memAddr), .memSize(memSize)
);

// File: tb/bitfield_mem_unit_tb.sv
`timescale 1ns/1ps
module bitfield_mem_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] baseAddr = '0, bitOffset = '0, srcValue = '0;
  logic [4:0]  widthCode = '0;
  logic        busy, done, memReq, memWrite;
  logic [31:0] result, memAddr;
  logic [1:0]  memSize;
  logic [63:0] memWdata;
  logic        memAck = 1'b0;
  logic [63:0] memRdata = '0;

  logic [7:0]  mem [256];
  logic [7:0]  refMem [256];
  int          accCount;
  logic [31:0] logAddr [4];
  logic [1:0]  logSize [4];
  logic        logWr [4];
  int          checks = 0, fails = 0;
  bit          finished = 0;

  always #2.5 clk = ~clk;

  bitfield_mem_unit u_dut (.*);

  always @(posedge clk) begin
    if (!rstN) memAck <= 1'b0;
    else if (memReq && !memAck) begin
      automatic int nb = 1 << memSize;
      automatic logic [63:0] tmp = '0;
      memAck <= 1'b1;
      if (accCount < 4) begin
        logAddr[accCount] = memAddr; logSize[accCount] = memSize;
        logWr[accCount] = memWrite;
      end
      accCount = accCount + 1;
      for (int b = 0; b < nb; b++) begin
        if (memWrite) mem[8'(memAddr + 32'(b))] <= memWdata[8*(nb-1-b) +: 8];
        tmp = (tmp << 8) | 64'(mem[8'(memAddr + 32'(b))]);
      end
      if (!memWrite) memRdata <= tmp;
    end else memAck <= 1'b0;
  end

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit refBit(int p);
    return refMem[8'(p >>> 3)][7 - (p & 7)];
  endfunction

  task automatic runOp(int opc, int base, int ofs, int wc, logic [31:0] src,
                       string tag, bit spoil);
    int len, p, bo, byteA, span, expSize, ffo, guard, bad;
    logic [31:0] fv, expRes;
    bit modify;
    len = (wc == 0) ? 32 : wc;               // R1
    p = base * 8 + ofs;
    fv = '0; ffo = -1;
    for (int i = 0; i < len; i++) begin
      fv = (fv << 1) | 32'(refBit(p + i));
      if (ffo < 0 && refBit(p + i)) ffo = i;
    end
    case (opc)
      1: expRes = fv[len-1] ? (fv | (~32'd0 << len)) : fv;
      2: expRes = src << (32 - len);
      3, 4, 5: expRes = fv << (32 - len);
      6: expRes = 32'(ofs + ((ffo < 0) ? len : ffo));
      default: expRes = fv;
    endcase
    modify = (opc >= 2 && opc <= 5);
    for (int i = 0; i < len; i++) begin
      automatic int q = p + i;
      automatic bit nb = refBit(q);
      case (opc)
        2: nb = src[len-1-i];
        3: nb = ~nb;
        4: nb = 1'b0;
        5: nb = 1'b1;
        default: ;
      endcase
      refMem[8'(q >>> 3)][7 - (q & 7)] = nb;
    end
    // R2/R3/R4 expected window
    bo = ofs & 7; byteA = base + (ofs >>> 3); span = (bo + len - 1) / 8;
    expSize = (span == 0) ? 0 : (span == 1) ? 1 : (span <= 3) ? 2 : 3;
    if (span == 2 && (byteA & 1)) byteA = byteA - 1;
    if (span == 4) byteA = byteA & ~3;

    @(negedge clk);
    accCount = 0;
    start = 1'b1; op = 3'(opc); baseAddr = 32'(base); bitOffset = 32'(ofs);
    widthCode = 5'(wc); srcValue = src;
    @(negedge clk);
    if (spoil) begin
      op = 3'd5; bitOffset = bitOffset + 32'd3; widthCode = 5'd7; srcValue = ~src;
      @(negedge clk);
    end
    start = 1'b0;
    guard = 0;
    while (!done && guard < 100) begin @(negedge clk); guard++; end
    check(done == 1'b1 && result == expRes, tag, 64'(result), 64'(expRes));
    bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== refMem[i]) bad++;
    check(bad == 0, "R7 memory image", 64'(bad), 64'd0);
    check(accCount >= 1 && !logWr[0] && logAddr[0] == 32'(byteA) &&
          logSize[0] == 2'(expSize), "R3 read window",
          {logAddr[0], 30'd0, logSize[0]}, {32'(byteA), 30'd0, 2'(expSize)});
    if (modify)
      check(accCount == 2 && logWr[1] && logAddr[1] == logAddr[0] &&
            logSize[1] == logSize[0], "R9 rmw pair", 64'(accCount), 64'd2);
    else
      check(accCount == 1, "R9 single read", 64'(accCount), 64'd1);
  endtask

  task automatic poke(int a, logic [7:0] v);
    mem[a] = v; refMem[a] = v;
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'($urandom); refMem[i] = mem[i];
    end
    repeat (4) @(negedge clk);
    // R11 reset state
    check(!busy && !done && !memReq, "R11 reset outputs",
          {61'd0, busy, done, memReq}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    // directed corners
    runOp(0, 64, 0, 0, 0, "R1 width code 0", 0);
    poke(100, 8'h0F); poke(101, 8'h80);
    runOp(1, 101, -3, 5, 0, "R2 negative offset signed", 0);
    runOp(1, 100, 4, 5, 0, "R5 signed extract", 0);
    runOp(0, 67, 5, 0, 0, "R4 quad realign", 0);
    runOp(0, 81, 2, 20, 0, "R4 odd long realign", 0);
    for (int a = 120; a < 126; a++) poke(a, 8'h00);
    runOp(6, 120, 3, 12, 0, "R8 find all zero", 0);
    poke(122, 8'h10);
    runOp(6, 120, 3, 20, 0, "R8 find first one", 0);
    runOp(2, 90, 6, 4, 32'hFFFF_FFF5, "R6 insert high bits", 0);
    runOp(3, 140, 1, 1, 0, "R7 change one bit", 0);
    runOp(4, 141, 7, 9, 0, "R7 clear", 0);
    runOp(5, 150, -9, 13, 0, "R7 set", 0);
    runOp(7, 160, 13, 11, 0, "R5 code 7 extract", 0);
    runOp(2, 110, 2, 8, 32'h0000_00A5, "R10 start while busy", 1);
    for (int n = 0; n < 300; n++) begin
      automatic int opc = int'($urandom % 8);
      runOp(opc, 40 + int'($urandom % 150), int'($urandom % 128) - 64,
            int'($urandom % 32), $urandom,
            (opc == 6) ? "R8 random" : (opc >= 2 && opc <= 5) ? "R7 random" :
            "R5 random", 0);
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R10 watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule